// File: doc/BRIEF.md
# Write-Coalescing Command Buffer Builder

This block turns a stream of register write requests, each a 20-bit register offset with a 32-bit value, into a packed command list held in an internal word RAM. Each instruction takes two 32-bit words and starts on an even word index. A lone write becomes a single-write instruction. A run of back-to-back writes to the same offset is folded into one indexed-write instruction. That instruction has a count word, a header, and then the values one after another.

When the list is complete, a finish pulse fills the rest of the current 64-byte line (16 words) with zeros and reports the list length in bytes. A registered read port lets the list be fetched word by word. A sticky overflow flag shows that a request was refused for lack of room. A clear pulse starts a new list.

Top module: `cmdbuf_coalescer`

## Requirements
- R1: When the offset differs from the most recent instruction's offset, two words are stored at the next even index E. Word E holds the value. Word E+1 holds 0x01 in bits 31:24, 0xF in bits 23:20 and the offset in bits 19:0.
- R2: When a write hits a most recent single-write instruction at index S with the same offset, that instruction is rewritten in place. Word S becomes the count 2. Word S+1 becomes 0x09 in bits 31:24, zero in bits 23:20 and the offset in bits 19:0. Word S+2 holds the earlier value and word S+3 the new one.
- R3: When a write hits a most recent indexed-write instruction with the same offset, the value is stored at the write position and the count word at S is incremented.
- R4: After an append leaves the write position odd, the word at that position is stored as zero.
- R5: Every instruction starts at an even word index. An odd write position is rounded up before a new pair is stored.
- R6: A request that arrives while the write position is above CAP_WORDS-2 stores nothing and leaves the write position unchanged. It sets the overflow output, which stays high until clear.
- R7: A finish pulse zeroes the words from the write position up to the next multiple of 16 words. It then raises tail_valid for one cycle with tail_bytes equal to 4 times that aligned position.
- R8: A merge compares the offset with the most recent instruction only. The sequence A, B, A gives three single-write instructions.
- R9: A clear pulse sets the write position to 0 and drops overflow. The first write after it is a single write at word 0, even if its offset matches the last write before the clear.
- R10: After finish, a write to the offset of the last instruction starts a new single-write instruction at the aligned position.
- R11: req_ready goes low in the cycle after a request is accepted and stored, and stays low while its words and any finish padding are written. rd_data shows the word at rd_addr one clock after rd_addr is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Starts a new list |
| finish | input | 1 | Pads to a 16-word line and reports the tail |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request is taken on a clock edge when valid and ready are both high |
| req_offset | input | 20 | Register offset |
| req_value | input | 32 | Register value |
| overflow | output | 1 | Sticky refused-request flag |
| tail_valid | output | 1 | One-cycle pulse when padding is done |
| tail_bytes | output | PTR_W+2 (9) | List length in bytes |
| rd_addr | input | IDX_W (6) | Word index to read |
| rd_data | output | 32 | Word read, one cycle later |

## Verification
The bench first fills the RAM with nonzero words. This exposes a missing odd-position zero, which would otherwise leave an old header word inside an indexed run. Runs of two and three equal offsets test the rewrite of a single write. A design that got this wrong would leave a count of 1, keep the 0x01 opcode, or lose the earlier value. The A, B, A pattern, a write after finish and a write after clear catch a design that merges with an older or stale instruction. Filling the buffer to the refusal threshold checks that the flag rises on the right request and that refused requests do not move the tail.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;
    localparam int OFS_W      = 20;
    localparam int LINE_WORDS = 16;
    localparam logic [7:0] OP_SINGLE   = 8'h01;
    localparam logic [7:0] OP_INDEXED  = 8'h09;
    localparam logic [3:0] BYTE_EN_ALL = 4'hF;

    typedef enum logic [1:0] {ST_IDLE, ST_SEQ, ST_PAD} state_e;
    typedef enum logic [1:0] {PL_EMIT, PL_CONVERT, PL_APPEND} plan_e;
endpackage

// File: rtl/cmdbuf_ram.sv
module cmdbuf_ram #(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] wa,
    input  logic [31:0]      wd,
    input  logic [IDX_W-1:0] ra,
    output logic [31:0]      rd
);
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
        rd <= mem[ra];
    end
endmodule

// File: rtl/cmdbuf_planner.sv
module cmdbuf_planner
    import cmdbuf_pkg::*;
#(
    parameter int CAP   = 64,
    parameter int IDX_W = 6,
    parameter int PTR_W = 7
) (
    input  logic [PTR_W-1:0]         wpos,
    input  logic [PTR_W-1:0]         start,
    input  logic [PTR_W-1:0]         count,
    input  logic                     hit_valid,
    input  logic                     last_indexed,
    input  logic [OFS_W-1:0]         last_ofs,
    input  logic [31:0]              last_val,
    input  logic [OFS_W-1:0]         req_offset,
    input  logic [31:0]              req_value,
    output logic                     refuse,
    output plan_e                    kind,
    output logic [2:0]               len,
    output logic [3:0][IDX_W-1:0]    wr_addr,
    output logic [3:0][31:0]         wr_data,
    output logic [PTR_W-1:0]         nxt_wpos,
    output logic [PTR_W-1:0]         nxt_start,
    output logic [PTR_W-1:0]         nxt_count
);
    localparam logic [PTR_W-1:0] P1 = PTR_W'(1);
    localparam logic [PTR_W-1:0] P2 = PTR_W'(2);
    localparam logic [PTR_W-1:0] P3 = PTR_W'(3);
    localparam logic [PTR_W-1:0] P4 = PTR_W'(4);
    localparam logic [PTR_W-1:0] LIMIT = PTR_W'(CAP - 2);

    logic [PTR_W-1:0] even_pos;
    logic [PTR_W-1:0] cnt_inc;
    logic             hit;

    always_comb begin
        even_pos  = wpos + {{(PTR_W-1){1'b0}}, wpos[0]};
        cnt_inc   = count + P1;
        hit       = hit_valid && (last_ofs == req_offset);
        refuse    = wpos > LIMIT;
        kind      = PL_EMIT;
        len       = 3'd2;
        wr_addr   = '0;
        wr_data   = '0;
        nxt_wpos  = wpos;
        nxt_start = start;
        nxt_count = count;
        if (!hit) begin
            wr_addr[0] = IDX_W'(even_pos);
            wr_data[0] = req_value;
            wr_addr[1] = IDX_W'(even_pos + P1);
            wr_data[1] = {OP_SINGLE, BYTE_EN_ALL, req_offset};
            nxt_wpos   = even_pos + P2;
            nxt_start  = even_pos;
            nxt_count  = '0;
        end else if (!last_indexed) begin
            kind       = PL_CONVERT;
            len        = 3'd4;
            wr_addr[0] = IDX_W'(start);
            wr_data[0] = 32'd2;
            wr_addr[1] = IDX_W'(start + P1);
            wr_data[1] = {OP_INDEXED, 4'h0, req_offset};
            wr_addr[2] = IDX_W'(start + P2);
            wr_data[2] = last_val;
            wr_addr[3] = IDX_W'(start + P3);
            wr_data[3] = req_value;
            nxt_wpos   = start + P4;
            nxt_count  = P2;
        end else begin
            kind       = PL_APPEND;
            wr_addr[0] = IDX_W'(wpos);
            wr_data[0] = req_value;
            wr_addr[1] = IDX_W'(start);
            wr_data[1] = {{(32-PTR_W){1'b0}}, cnt_inc};
            if (!wpos[0]) begin
                len        = 3'd3;
                wr_addr[2] = IDX_W'(wpos + P1);
                wr_data[2] = 32'd0;
            end
            nxt_wpos  = wpos + P1;
            nxt_count = cnt_inc;
        end
    end
endmodule

// File: rtl/cmdbuf_coalescer.sv
module cmdbuf_coalescer
    import cmdbuf_pkg::*;
#(
    parameter  int CAP_WORDS = 64,
    localparam int IDX_W     = $clog2(CAP_WORDS),
    localparam int PTR_W     = $clog2(CAP_WORDS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               finish,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [19:0]        req_offset,
    input  logic [31:0]        req_value,
    output logic               overflow,
    output logic               tail_valid,
    output logic [PTR_W+1:0]   tail_bytes,
    input  logic [IDX_W-1:0]   rd_addr,
    output logic [31:0]        rd_data
);
    localparam logic [PTR_W-1:0] LINE_MASK = PTR_W'(LINE_WORDS - 1);

    typedef struct packed {
        state_e                  st;
        logic [PTR_W-1:0]        wpos;
        logic [PTR_W-1:0]        start;
        logic [PTR_W-1:0]        count;
        logic [PTR_W-1:0]        pad_end;
        logic                    hit_valid;
        logic                    last_indexed;
        logic [OFS_W-1:0]        last_ofs;
        logic [31:0]             last_val;
        logic [1:0]              step;
        logic [2:0]              len;
        logic [3:0][IDX_W-1:0]   sa;
        logic [3:0][31:0]        sd;
        logic                    ovf;
        logic                    tail_v;
        logic [PTR_W+1:0]        tail;
    } state_t;

    state_t s_d, s_q;

    logic                   p_refuse;
    plan_e                  p_kind;
    logic [2:0]             p_len;
    logic [3:0][IDX_W-1:0]  p_addr;
    logic [3:0][31:0]       p_data;
    logic [PTR_W-1:0]       p_wpos, p_start, p_count;

    logic                   mem_we;
    logic [IDX_W-1:0]       mem_wa;
    logic [31:0]            mem_wd;

    logic [PTR_W-1:0]       wpos_q, start_q;

    cmdbuf_planner #(.CAP(CAP_WORDS), .IDX_W(IDX_W), .PTR_W(PTR_W)) u_plan (
        .wpos(s_q.wpos), .start(s_q.start), .count(s_q.count),
        .hit_valid(s_q.hit_valid), .last_indexed(s_q.last_indexed),
        .last_ofs(s_q.last_ofs), .last_val(s_q.last_val),
        .req_offset(req_offset), .req_value(req_value),
        .refuse(p_refuse), .kind(p_kind), .len(p_len),
        .wr_addr(p_addr), .wr_data(p_data),
        .nxt_wpos(p_wpos), .nxt_start(p_start), .nxt_count(p_count)
    );

    cmdbuf_ram #(.DEPTH(CAP_WORDS), .IDX_W(IDX_W)) u_ram (
        .clk(clk), .we(mem_we), .wa(mem_wa), .wd(mem_wd),
        .ra(rd_addr), .rd(rd_data)
    );

    always_comb begin
        s_d        = s_q;
        s_d.tail_v = 1'b0;
        mem_we     = 1'b0;
        mem_wa     = '0;
        mem_wd     = '0;
        if (clear) begin
            s_d.st        = ST_IDLE;
            s_d.wpos      = '0;
            s_d.start     = '0;
            s_d.count     = '0;
            s_d.hit_valid = 1'b0;
            s_d.ovf       = 1'b0;
            s_d.tail      = '0;
        end else begin
            unique case (s_q.st)
                ST_IDLE: begin
                    if (finish) begin
                        s_d.pad_end   = (s_q.wpos + LINE_MASK) & ~LINE_MASK;
                        s_d.hit_valid = 1'b0;
                        s_d.st        = ST_PAD;
                    end else if (req_valid) begin
                        if (p_refuse) begin
                            s_d.ovf = 1'b1;
                        end else begin
                            s_d.sa           = p_addr;
                            s_d.sd           = p_data;
                            s_d.len          = p_len;
                            s_d.step         = '0;
                            s_d.st           = ST_SEQ;
                            s_d.wpos         = p_wpos;
                            s_d.start        = p_start;
                            s_d.count        = p_count;
                            s_d.hit_valid    = 1'b1;
                            s_d.last_indexed = (p_kind != PL_EMIT);
                            s_d.last_ofs     = req_offset;
                            s_d.last_val     = req_value;
                        end
                    end
                end
                ST_SEQ: begin
                    mem_we   = 1'b1;
                    mem_wa   = s_q.sa[s_q.step];
                    mem_wd   = s_q.sd[s_q.step];
                    s_d.step = s_q.step + 2'd1;
                    if ({1'b0, s_q.step} == s_q.len - 3'd1) s_d.st = ST_IDLE;
                end
                ST_PAD: begin
                    if (s_q.wpos == s_q.pad_end) begin
                        s_d.tail_v = 1'b1;
                        s_d.tail   = {s_q.wpos, 2'b00};
                        s_d.st     = ST_IDLE;
                    end else begin
                        mem_we   = 1'b1;
                        mem_wa   = IDX_W'(s_q.wpos);
                        s_d.wpos = s_q.wpos + PTR_W'(1);
                    end
                end
                default: s_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready  = (s_q.st == ST_IDLE) && !clear && !finish;
    assign overflow   = s_q.ovf;
    assign tail_valid = s_q.tail_v;
    assign tail_bytes = s_q.tail;
    assign wpos_q     = s_q.wpos;
    assign start_q    = s_q.start;
endmodule

// File: rtl/cmdbuf_coalescer_chk.sv
module cmdbuf_coalescer_chk #(
    parameter int CAP   = 64,
    parameter int PTR_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear,
    input logic             req_valid,
    input logic             req_ready,
    input logic             overflow,
    input logic             tail_valid,
    input logic [PTR_W+1:0] tail_bytes,
    input logic [PTR_W-1:0] wpos,
    input logic [PTR_W-1:0] start
);
    localparam logic [PTR_W-1:0] LIMIT = PTR_W'(CAP - 2);
    localparam logic [PTR_W-1:0] CAPP  = PTR_W'(CAP);

    assert_tail_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tail_valid |-> (tail_bytes[5:0] == 6'd0));
    assert_tail_is_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tail_valid |-> (tail_bytes == {wpos, 2'b00}));
    assert_start_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start[0] == 1'b0);
    assert_pos_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wpos <= CAPP);
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clear) |=> overflow);
    assert_refuse_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && wpos > LIMIT) |=> (overflow && $stable(wpos)));
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (wpos == '0 && start == '0 && !overflow));
    assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && wpos <= LIMIT) |=> !req_ready);
endmodule

bind cmdbuf_coalescer cmdbuf_coalescer_chk #(.CAP(CAP_WORDS), .PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clear(clear), .req_valid(req_valid),
    .req_ready(req_ready), .overflow(overflow), .tail_valid(tail_valid),
    .tail_bytes(tail_bytes), .wpos(wpos_q), .start(start_q)
);

// File: tb/cmdbuf_coalescer_tb.sv
module cmdbuf_coalescer_tb;
    localparam int CAP   = 64;
    localparam int IDX_W = 6;
    localparam int PTR_W = 7;

    logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0, finish = 1'b0, req_valid = 1'b0;
    logic req_ready, overflow, tail_valid;
    logic [19:0] req_offset = '0;
    logic [31:0] req_value = '0;
    logic [PTR_W+1:0] tail_bytes;
    logic [IDX_W-1:0] rd_addr = '0;
    logic [31:0] rd_data;

    always #2 clk = ~clk;

    cmdbuf_coalescer #(.CAP_WORDS(CAP)) u_dut (.*);

    int checks = 0, fails = 0;
    logic [31:0] mbuf [CAP];
    int  mpos = 0, mstart = 0;
    bit  mvalid = 0, movf = 0;
    logic ready_after = 1'b1;
    int  last_tail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic void m_write(input logic [19:0] ofs, input logic [31:0] val);
        logic [7:0] pop;
        logic [19:0] preg;
        if (mpos > CAP - 2) begin movf = 1; return; end
        pop  = mbuf[mstart+1][31:24];
        preg = mbuf[mstart+1][19:0];
        if (!mvalid || preg != ofs) begin
            mpos = (mpos + 1) & ~1;
            mstart = mpos;
            mbuf[mpos] = val;
            mbuf[mpos+1] = {8'h01, 4'hF, ofs};
            mpos += 2;
            mvalid = 1;
            return;
        end
        if (pop == 8'h01) begin
            mbuf[mstart+2] = mbuf[mstart];
            mbuf[mstart]   = 32'd1;
            mbuf[mstart+1] = {8'h09, 4'h0, ofs};
            mpos++;
        end
        mbuf[mpos] = val;
        mpos++;
        mbuf[mstart] = mbuf[mstart] + 32'd1;
        if (mpos % 2 == 1) mbuf[mpos] = 32'd0;
    endfunction

    function automatic int m_finish();
        while (mpos % 16 != 0) begin mbuf[mpos] = 32'd0; mpos++; end
        mvalid = 0;
        return mpos * 4;
    endfunction

    task automatic do_write(input logic [19:0] ofs, input logic [31:0] val);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_offset = ofs; req_value = val;
        @(posedge clk); #1 req_valid = 1'b0;
        @(negedge clk);
        ready_after = req_ready;
        while (!req_ready) @(negedge clk);
        m_write(ofs, val);
    endtask

    task automatic do_finish(input string req);
        int exp_tail;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        finish = 1'b1;
        @(posedge clk); #1 finish = 1'b0;
        @(negedge clk);
        while (!tail_valid) @(negedge clk);
        exp_tail = m_finish();
        last_tail = exp_tail;
        check(tail_bytes == (PTR_W+2)'(exp_tail), req, "tail bytes",
              32'(tail_bytes), 32'(exp_tail));
    endtask

    task automatic do_clear();
        @(negedge clk); clear = 1'b1;
        @(posedge clk); #1 clear = 1'b0;
        mpos = 0; mstart = 0; mvalid = 0; movf = 0;
    endtask

    task automatic rd(input int idx, output logic [31:0] d);
        @(negedge clk); rd_addr = IDX_W'(idx);
        @(posedge clk);
        @(negedge clk); d = rd_data;
    endtask

    task automatic cmp_word(input int idx, input logic [31:0] exp, input string req);
        logic [31:0] d;
        rd(idx, d);
        check(d === exp, req, $sformatf("word %0d", idx), d, exp);
    endtask

    task automatic cmp_range(input int n, input string req);
        for (int i = 0; i < n; i++) cmp_word(i, mbuf[i], req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [19:0] ofs;
        int unsigned seed;
        seed = $urandom(32'h5EED);
        for (int i = 0; i < CAP; i++) mbuf[i] = 32'd0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R11", "ready after reset", 32'(req_ready), 32'd1);
        check(overflow == 1'b0, "R6", "overflow after reset", 32'(overflow), 32'd0);
        check(tail_valid == 1'b0, "R7", "tail_valid after reset", 32'(tail_valid), 32'd0);

        // Fill with nonzero content so a missing zero word is visible.
        for (int i = 0; i < 20; i++) do_write(20'h01000 + 20'(i*4), 32'hC0DE0000 + 32'(i));
        do_clear();

        do_write(20'h00100, 32'hAAAA5555);
        check(ready_after == 1'b0, "R11", "ready low after accept", 32'(ready_after), 32'd0);
        cmp_word(0, 32'hAAAA5555, "R1");
        cmp_word(1, 32'h01F00100, "R1");
        do_write(20'h00100, 32'h11111111);
        cmp_word(0, 32'd2, "R2");
        cmp_word(1, 32'h09000100, "R2");
        cmp_word(2, 32'hAAAA5555, "R2");
        cmp_word(3, 32'h11111111, "R2");
        do_write(20'h00100, 32'h22222222);
        cmp_word(0, 32'd3, "R3");
        cmp_word(4, 32'h22222222, "R3");
        cmp_word(5, 32'd0, "R4");
        do_write(20'h00200, 32'h33333333);
        cmp_word(6, 32'h33333333, "R5");
        cmp_word(7, 32'h01F00200, "R5");
        do_write(20'h00300, 32'h44444444);
        do_write(20'h00304, 32'h55555555);
        do_write(20'h00300, 32'h66666666);
        cmp_word(13, 32'h01F00300, "R8");
        cmp_word(12, 32'h66666666, "R8");
        do_finish("R7");
        check(last_tail == 64, "R7", "tail model", 32'(last_tail), 32'd64);
        cmp_range(16, "R7");
        do_write(20'h00300, 32'h77777777);
        cmp_word(16, 32'h77777777, "R10");
        cmp_word(17, 32'h01F00300, "R10");

        for (int i = 0; i < 30; i++) begin
            do_write(20'h02000 + 20'(i*4), 32'hB0000000 + 32'(i));
            check(overflow == movf, "R6", $sformatf("overflow after fill %0d", i),
                  32'(overflow), 32'(movf));
        end
        do_finish("R6");
        cmp_range(CAP, "R6");

        do_clear();
        @(negedge clk);
        check(overflow == 1'b0, "R9", "overflow after clear", 32'(overflow), 32'd0);
        do_write(20'h02074, 32'h88888888);
        cmp_word(0, 32'h88888888, "R9");
        cmp_word(1, 32'h01F02074, "R9");

        for (int r = 0; r < 8; r++) begin
            int n;
            do_clear();
            n = 10 + int'($urandom % 30);
            ofs = 20'h00100;
            for (int k = 0; k < n; k++) begin
                if ($urandom % 2 == 0) begin
                    case ($urandom % 3)
                        0: ofs = 20'h00100;
                        1: ofs = 20'h00104;
                        default: ofs = 20'hFFFFC;
                    endcase
                end
                do_write(ofs, $urandom);
            end
            check(overflow == movf, "R6", $sformatf("random overflow round %0d", r),
                  32'(overflow), 32'(movf));
            do_finish("R7");
            cmp_range(last_tail / 4, "R3");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule